// File: doc/BRIEF.md
# Token-Counting Coherence Permission Unit

This block keeps coherence permission for a small set of cache lines as a count of tokens rather than as a named state. Each line has a fixed system-wide pool of `TOKENS` tokens, and exactly one of them is the owner token. For every line the unit holds the local token count, a flag saying whether the owner token is held, and a data-valid bit. A local write may proceed only when every token of the line is held. A local read needs at least one token and valid data.

Inbound coherence messages deliver tokens, and possibly the owner token and data. Data is represented only by a has-data flag. When another node asks for a line, the unit builds an outbound token transfer. An exclusive request gives up every held token. A shared request gives up all but one non-owner token. A processor operation that lacks permission is parked in a single pending slot. It is re-examined each time its line's count changes and is granted as soon as the permission rule allows it.

A side port lets the caller read any line's count, owner flag, valid bit and derived MSI-style state.

Top module: `tokperm_unit`

## Requirements
- R1: After reset every line has count 0, no owner token, data-valid clear and state code 0. No outbound message, grant, pending operation or error is reported.
- R2: An accepted inbound message adds `in_tokens` to its line's count. If `in_owner` is set, it also sets that line's owner flag. Both changes are visible on the query port the cycle after the message.
- R3: An inbound message is rejected when any of these holds:
  - the count after this cycle's outbound removal plus `in_tokens` would exceed `TOKENS`;
  - it carries the owner token while the line keeps one;
  - it carries the owner token with zero tokens.
  A rejected message leaves the line unchanged and raises `tok_err` for one cycle on the next cycle.
- R4: Data-valid is set when an accepted data-carrying message brings at least one token. It is cleared whenever the count becomes 0. Data without tokens has no effect on it.
- R5: `q_state` is 2'b00 for count 0, 2'b01 for counts 1 to `TOKENS`-1, and 2'b10 for count `TOKENS`.
- R6: A read operation is granted only while its line has count of at least 1 and data-valid set.
- R7: A write operation is granted only while its line has count equal to `TOKENS`. `op_grant_wr` marks the grant as a write.
- R8: An exclusive external request (`ext_excl`=1) sends all held tokens and the owner flag if held. It sends nothing when the count is 0. The message appears on `out_*` the cycle after the request.
- R9: A shared external request behaves by count:
  - count above 1: sends count-1 tokens including the owner token if held, and keeps one non-owner token;
  - count of exactly 1 with the owner token: sends that token;
  - otherwise: sends nothing.
- R10: An outbound message has `out_data` set exactly when it carries the owner token.
- R11: A new operation without permission makes `op_busy` high from the next cycle. The parked operation is re-checked in the cycle after each change of its line's count, and it is granted with `op_busy` dropping once the rule holds.
- R12: When an external request and an inbound message hit the same line in one cycle, the outbound message is computed from the count before the cycle. The new count is the old count minus the tokens sent plus the tokens received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound token message present |
| in_line | input | LW | Line addressed by the inbound message |
| in_tokens | input | CW | Tokens carried, including the owner token |
| in_owner | input | 1 | Message carries the owner token |
| in_data | input | 1 | Message carries data |
| ext_valid | input | 1 | External request from another node |
| ext_line | input | LW | Line asked for |
| ext_excl | input | 1 | 1 = exclusive request, 0 = shared request |
| out_valid | output | 1 | Outbound token message present |
| out_line | output | LW | Line of the outbound message |
| out_tokens | output | CW | Tokens sent |
| out_owner | output | 1 | Owner token sent |
| out_data | output | 1 | Data sent |
| op_valid | input | 1 | New processor operation, only while op_busy is low |
| op_write | input | 1 | 1 = write, 0 = read |
| op_line | input | LW | Line of the operation |
| op_grant | output | 1 | One-cycle grant pulse |
| op_grant_wr | output | 1 | The granted operation is a write |
| op_busy | output | 1 | An operation is parked awaiting permission |
| q_line | input | LW | Line to inspect |
| q_count | output | CW | Token count of the inspected line |
| q_owner | output | 1 | Owner flag of the inspected line |
| q_valid | output | 1 | Data-valid of the inspected line |
| q_state | output | 2 | Derived state: 0 invalid, 1 shared, 2 modified |
| tok_err | output | 1 | Pulse: an inbound message was rejected |

## Verification
The assertions assume that `op_valid` is raised only while `op_busy` is low, and that every line index is below `NUM_LINES`. On that basis they hold that a count never exceeds the pool, that an owner flag or a valid bit never outlives the last token, and that grants agree with the count seen a cycle earlier. The stimulus draws lines from a small subset so that inbound messages, external requests and parked operations collide often. It issues operations only while the bench's own model shows the slot free. It deliberately sends over-full and duplicate-owner messages, because the unit must reject those itself rather than assume them away.

// File: rtl/tokperm_pkg.sv
package tokperm_pkg;

   typedef enum logic [1:0] {
      TS_INV = 2'b00,
      TS_SHR = 2'b01,
      TS_MOD = 2'b10
   } tok_state_e;

   function automatic tok_state_e state_of(input int unsigned cnt, input int unsigned full);
      if (cnt == 0)
         return TS_INV;
      else if (cnt >= full)
         return TS_MOD;
      else
         return TS_SHR;
   endfunction

endpackage

// File: rtl/tokperm_store.sv
module tokperm_store #(
   parameter int NUM_LINES = 8,
   parameter int TOKENS    = 4,
   parameter int LW        = 3,
   parameter int CW        = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [LW-1:0]                 in_line,
   input  logic [CW-1:0]                 in_tokens,
   input  logic                          in_owner,
   input  logic                          in_data,
   input  logic                          rm_fire,
   input  logic [LW-1:0]                 rm_line,
   input  logic [CW-1:0]                 rm_tokens,
   input  logic                          rm_owner,
   output logic [NUM_LINES-1:0][CW-1:0]  cnt_vec,
   output logic [NUM_LINES-1:0]          own_vec,
   output logic [NUM_LINES-1:0]          val_vec,
   output logic [NUM_LINES-1:0]          chg_vec,
   output logic                          err_q
);
   localparam logic [CW:0] FULL_W = (CW+1)'(TOKENS);

   logic [NUM_LINES-1:0] bad_vec;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic [CW-1:0] cnt_q, take, give, mid, nxt;
      logic          own_q, val_q, chg_q;
      logic          hit_in, hit_rm, take_own, give_own, own_mid, bad, ok, nown, nval;

      always_comb begin
         hit_in   = in_valid && (in_line == LW'(i));
         hit_rm   = rm_fire && (rm_line == LW'(i));
         take     = hit_rm ? rm_tokens : '0;
         take_own = hit_rm && rm_owner;
         give     = hit_in ? in_tokens : '0;
         give_own = hit_in && in_owner;
         mid      = cnt_q - take;
         own_mid  = own_q && !take_own;
         bad      = hit_in && ((({1'b0, mid} + {1'b0, give}) > FULL_W) ||
                               (give_own && own_mid) ||
                               (give_own && (give == '0)));
         ok       = hit_in && !bad;
         nxt      = ok ? (mid + give) : mid;
         nown     = own_mid || (ok && give_own);
         if (nxt == '0)
            nval = 1'b0;
         else if (ok && in_data && (give != '0))
            nval = 1'b1;
         else
            nval = val_q;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
            own_q <= 1'b0;
            val_q <= 1'b0;
            chg_q <= 1'b0;
         end else begin
            cnt_q <= nxt;
            own_q <= nown;
            val_q <= nval;
            chg_q <= (nxt != cnt_q);
         end
      end

      assign cnt_vec[i] = cnt_q;
      assign own_vec[i] = own_q;
      assign val_vec[i] = val_q;
      assign chg_vec[i] = chg_q;
      assign bad_vec[i] = bad;

      // R3: the count never leaves the pool
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         {1'b0, cnt_q} <= FULL_W);
      // R4: valid data never survives the last token
      p_valid_needs_tok_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == '0) |-> !val_q);
      // R2: the owner token is counted in the total
      p_owner_needs_tok_r2: assert property (@(posedge clk) disable iff (!rst_n)
         own_q |-> (cnt_q != '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= |bad_vec;
   end

endmodule

// File: rtl/tokperm_responder.sv
module tokperm_responder #(
   parameter int NUM_LINES = 8,
   parameter int LW        = 3,
   parameter int CW        = 3
) (
   input  logic                          ext_valid,
   input  logic [LW-1:0]                 ext_line,
   input  logic                          ext_excl,
   input  logic [NUM_LINES-1:0][CW-1:0]  cnt_vec,
   input  logic [NUM_LINES-1:0]          own_vec,
   output logic                          fire,
   output logic [CW-1:0]                 take,
   output logic                          take_owner
);
   logic [CW-1:0] cur;
   logic          cur_own;

   always_comb begin
      cur        = cnt_vec[ext_line];
      cur_own    = own_vec[ext_line];
      fire       = 1'b0;
      take       = '0;
      take_owner = 1'b0;
      if (ext_valid) begin
         if (ext_excl) begin
            if (cur != '0) begin
               fire       = 1'b1;
               take       = cur;
               take_owner = cur_own;
            end
         end else if (cur > CW'(1)) begin
            fire       = 1'b1;
            take       = cur - CW'(1);
            take_owner = cur_own;
         end else if ((cur == CW'(1)) && cur_own) begin
            fire       = 1'b1;
            take       = CW'(1);
            take_owner = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tokperm_retry.sv
module tokperm_retry #(
   parameter int NUM_LINES = 8,
   parameter int TOKENS    = 4,
   parameter int LW        = 3,
   parameter int CW        = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          op_valid,
   input  logic                          op_write,
   input  logic [LW-1:0]                 op_line,
   input  logic [NUM_LINES-1:0][CW-1:0]  cnt_vec,
   input  logic [NUM_LINES-1:0]          val_vec,
   input  logic [NUM_LINES-1:0]          chg_vec,
   output logic                          op_grant,
   output logic                          op_grant_wr,
   output logic                          op_busy
);
   localparam logic [CW-1:0] FULL = CW'(TOKENS);

   logic          pend_q, pend_wr_q;
   logic [LW-1:0] pend_line_q;
   logic          new_ok, pend_ok;
   logic [CW-1:0] sel_cnt;
   logic          sel_val;

   always_comb begin
      new_ok  = op_write ? (cnt_vec[op_line] == FULL)
                         : ((cnt_vec[op_line] != '0) && val_vec[op_line]);
      pend_ok = pend_wr_q ? (cnt_vec[pend_line_q] == FULL)
                          : ((cnt_vec[pend_line_q] != '0) && val_vec[pend_line_q]);
      sel_cnt = pend_q ? cnt_vec[pend_line_q] : cnt_vec[op_line];
      sel_val = pend_q ? val_vec[pend_line_q] : val_vec[op_line];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_wr_q   <= 1'b0;
         pend_line_q <= '0;
         op_grant    <= 1'b0;
         op_grant_wr <= 1'b0;
      end else begin
         op_grant <= 1'b0;
         if (!pend_q) begin
            if (op_valid) begin
               if (new_ok) begin
                  op_grant    <= 1'b1;
                  op_grant_wr <= op_write;
               end else begin
                  pend_q      <= 1'b1;
                  pend_wr_q   <= op_write;
                  pend_line_q <= op_line;
               end
            end
         end else if (chg_vec[pend_line_q] && pend_ok) begin
            op_grant    <= 1'b1;
            op_grant_wr <= pend_wr_q;
            pend_q      <= 1'b0;
         end
      end
   end

   assign op_busy = pend_q;

   // R7: a write grant follows a full count
   p_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_grant && op_grant_wr) |-> ($past(sel_cnt) == FULL));
   // R6: a read grant follows a token with valid data
   p_rd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_grant && !op_grant_wr) |-> ($past(sel_val) && ($past(sel_cnt) != '0)));
   // R11: no grant is reported while an operation is still parked
   p_busy_no_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
      op_busy |-> !op_grant);

endmodule

// File: rtl/tokperm_unit.sv
module tokperm_unit #(
   parameter int NUM_LINES = 8,
   parameter int NUM_PROCS = 4,
   parameter int TOKENS    = 4,
   parameter bit OUT_REG   = 1'b1,
   localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int CW = $clog2(TOKENS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [LW-1:0] in_line,
   input  logic [CW-1:0] in_tokens,
   input  logic          in_owner,
   input  logic          in_data,
   input  logic          ext_valid,
   input  logic [LW-1:0] ext_line,
   input  logic          ext_excl,
   output logic          out_valid,
   output logic [LW-1:0] out_line,
   output logic [CW-1:0] out_tokens,
   output logic          out_owner,
   output logic          out_data,
   input  logic          op_valid,
   input  logic          op_write,
   input  logic [LW-1:0] op_line,
   output logic          op_grant,
   output logic          op_grant_wr,
   output logic          op_busy,
   input  logic [LW-1:0] q_line,
   output logic [CW-1:0] q_count,
   output logic          q_owner,
   output logic          q_valid,
   output logic [1:0]    q_state,
   output logic          tok_err
);
   import tokperm_pkg::*;

   if (TOKENS < NUM_PROCS) begin : g_chk_pool
      $error("token pool smaller than processor count");
   end
   if (NUM_LINES < 1) begin : g_chk_lines
      $error("at least one line is required");
   end

   logic [NUM_LINES-1:0][CW-1:0] cnt_vec;
   logic [NUM_LINES-1:0]         own_vec, val_vec, chg_vec;
   logic                         rsp_fire, rsp_owner;
   logic [CW-1:0]                rsp_take;

   tokperm_responder #(.NUM_LINES(NUM_LINES), .LW(LW), .CW(CW)) u_rsp (
      .ext_valid (ext_valid),
      .ext_line  (ext_line),
      .ext_excl  (ext_excl),
      .cnt_vec   (cnt_vec),
      .own_vec   (own_vec),
      .fire      (rsp_fire),
      .take      (rsp_take),
      .take_owner(rsp_owner)
   );

   tokperm_store #(.NUM_LINES(NUM_LINES), .TOKENS(TOKENS), .LW(LW), .CW(CW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_line  (in_line),
      .in_tokens(in_tokens),
      .in_owner (in_owner),
      .in_data  (in_data),
      .rm_fire  (rsp_fire),
      .rm_line  (ext_line),
      .rm_tokens(rsp_take),
      .rm_owner (rsp_owner),
      .cnt_vec  (cnt_vec),
      .own_vec  (own_vec),
      .val_vec  (val_vec),
      .chg_vec  (chg_vec),
      .err_q    (tok_err)
   );

   tokperm_retry #(.NUM_LINES(NUM_LINES), .TOKENS(TOKENS), .LW(LW), .CW(CW)) u_retry (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_write   (op_write),
      .op_line    (op_line),
      .cnt_vec    (cnt_vec),
      .val_vec    (val_vec),
      .chg_vec    (chg_vec),
      .op_grant   (op_grant),
      .op_grant_wr(op_grant_wr),
      .op_busy    (op_busy)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_line   <= '0;
            out_tokens <= '0;
            out_owner  <= 1'b0;
            out_data   <= 1'b0;
         end else begin
            out_valid  <= rsp_fire;
            out_line   <= ext_line;
            out_tokens <= rsp_take;
            out_owner  <= rsp_owner;
            out_data   <= rsp_owner;
         end
      end
   end else begin : g_out_comb
      assign out_valid  = rsp_fire;
      assign out_line   = ext_line;
      assign out_tokens = rsp_take;
      assign out_owner  = rsp_owner;
      assign out_data   = rsp_owner;
   end

   always_comb begin
      q_count = cnt_vec[q_line];
      q_owner = own_vec[q_line];
      q_valid = val_vec[q_line];
      q_state = state_of(int'(cnt_vec[q_line]), TOKENS);
   end

   // R8: a transfer always moves at least one token
   p_out_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_tokens != '0));
   // R10: the owner token never travels without data
   p_out_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_owner) |-> out_data);

endmodule

// File: tb/sim_tokperm_unit.sv
`timescale 1ns/1ps
module sim_tokperm_unit;
   localparam int NL = 8;
   localparam int T  = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_owner, in_data, ext_valid, ext_excl, op_valid, op_write;
   logic [2:0] in_line, ext_line, op_line, q_line, in_tokens;
   logic       out_valid, out_owner, out_data, op_grant, op_grant_wr, op_busy;
   logic       q_owner, q_valid, tok_err;
   logic [2:0] out_line, out_tokens, q_count;
   logic [1:0] q_state;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int m_cnt [NL];
   bit m_own [NL];
   bit m_val [NL];
   bit m_chg [NL];
   bit m_pend, m_pw;
   int m_pl;
   bit e_fire, e_town, e_gr, e_gw, e_err;
   int e_take, e_line;

   always #2 clk = ~clk;

   tokperm_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_line(in_line), .in_tokens(in_tokens),
      .in_owner(in_owner), .in_data(in_data),
      .ext_valid(ext_valid), .ext_line(ext_line), .ext_excl(ext_excl),
      .out_valid(out_valid), .out_line(out_line), .out_tokens(out_tokens),
      .out_owner(out_owner), .out_data(out_data),
      .op_valid(op_valid), .op_write(op_write), .op_line(op_line),
      .op_grant(op_grant), .op_grant_wr(op_grant_wr), .op_busy(op_busy),
      .q_line(q_line), .q_count(q_count), .q_owner(q_owner), .q_valid(q_valid),
      .q_state(q_state), .tok_err(tok_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit perm(input int ln, input bit wr);
      return wr ? (m_cnt[ln] == T) : (m_cnt[ln] != 0 && m_val[ln]);
   endfunction

   function automatic int st_of(input int c);
      return (c == 0) ? 0 : ((c == T) ? 2 : 1);
   endfunction

   task automatic check_line(input int ln);
      q_line = 3'(ln);
      #1;
      chk("R2 count", int'(q_count), m_cnt[ln]);
      chk("R2 owner", int'(q_owner), int'(m_own[ln]));
      chk("R4 valid", int'(q_valid), int'(m_val[ln]));
      chk("R5 state", int'(q_state), st_of(m_cnt[ln]));
   endtask

   // one cycle: drive, predict, clock, compare
   task automatic cyc(input bit iv, input int il, input int it, input bit io, input bit id,
                      input bit xv, input int xl, input bit xx,
                      input bit ov, input bit ow, input int ol);
      int c;
      in_valid = iv; in_line = 3'(il); in_tokens = 3'(it); in_owner = io; in_data = id;
      ext_valid = xv; ext_line = 3'(xl); ext_excl = xx;
      op_valid = ov; op_write = ow; op_line = 3'(ol);
      // external response from the count before the cycle (R8, R9, R12)
      c = m_cnt[xl];
      e_fire = 0; e_take = 0; e_town = 0; e_line = xl;
      if (xv) begin
         if (xx) begin
            if (c > 0) begin e_fire = 1; e_take = c; e_town = m_own[xl]; end
         end else if (c > 1) begin
            e_fire = 1; e_take = c - 1; e_town = m_own[xl];
         end else if (c == 1 && m_own[xl]) begin
            e_fire = 1; e_take = 1; e_town = 1;
         end
      end
      // permission and retry (R6, R7, R11)
      e_gr = 0; e_gw = 0;
      if (!m_pend) begin
         if (ov) begin
            if (perm(ol, ow)) begin e_gr = 1; e_gw = ow; end
            else begin m_pend = 1; m_pw = ow; m_pl = ol; end
         end
      end else if (m_chg[m_pl] && perm(m_pl, m_pw)) begin
         e_gr = 1; e_gw = m_pw; m_pend = 0;
      end
      // token bookkeeping (R2, R3, R4)
      e_err = 0;
      for (int i = 0; i < NL; i++) begin
         int mid, add, nxt;
         bit omid, bad, ok;
         mid  = m_cnt[i] - ((e_fire && xl == i) ? e_take : 0);
         omid = m_own[i] && !(e_fire && xl == i && e_town);
         add  = (iv && il == i) ? it : 0;
         bad  = iv && il == i && ((mid + add > T) || (io && omid) || (io && it == 0));
         ok   = iv && il == i && !bad;
         if (bad) e_err = 1;
         nxt  = ok ? mid + add : mid;
         m_own[i] = omid || (ok && io);
         if (nxt == 0) m_val[i] = 0;
         else if (ok && id && add != 0) m_val[i] = 1;
         m_chg[i] = (nxt != m_cnt[i]);
         m_cnt[i] = nxt;
      end
      @(posedge clk);
      #1;
      chk(xx ? "R8 out_valid" : "R9 out_valid", int'(out_valid), int'(e_fire));
      if (e_fire) begin
         chk("R12 out_line", int'(out_line), e_line);
         chk(xx ? "R8 out_tokens" : "R9 out_tokens", int'(out_tokens), e_take);
         chk("R8 out_owner", int'(out_owner), int'(e_town));
         chk("R10 out_data", int'(out_data), int'(e_town));
      end
      chk("R6 grant", int'(op_grant), int'(e_gr));
      if (e_gr) chk("R7 grant_wr", int'(op_grant_wr), int'(e_gw));
      chk("R11 busy", int'(op_busy), int'(m_pend));
      chk("R3 err", int'(tok_err), int'(e_err));
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'h1d2c3b4a;
      void'($urandom(seed));
      for (int i = 0; i < NL; i++) begin
         m_cnt[i] = 0; m_own[i] = 0; m_val[i] = 0; m_chg[i] = 0;
      end
      m_pend = 0; m_pw = 0; m_pl = 0;
      rst_n = 0;
      in_valid = 0; in_line = 0; in_tokens = 0; in_owner = 0; in_data = 0;
      ext_valid = 0; ext_line = 0; ext_excl = 0;
      op_valid = 0; op_write = 0; op_line = 0; q_line = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      // R1: reset state
      for (int i = 0; i < NL; i++) begin
         q_line = 3'(i);
         #0.1;
         chk("R1 count", int'(q_count), 0);
         chk("R1 state", int'(q_state), 0);
         chk("R1 valid", int'(q_valid), 0);
      end
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 busy", int'(op_busy), 0);
      chk("R1 err", int'(tok_err), 0);
      // R2 R5: full pool with owner and data -> modified
      cyc(1, 1, T, 1, 1, 0, 0, 0, 0, 0, 0);
      check_line(1);
      chk("R5 modified", int'(q_state), 2);
      // R7: write granted with all tokens
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
      chk("R7 write grant", int'(op_grant && op_grant_wr), 1);
      // R9: shared request keeps one non-owner token
      cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      chk("R9 sent", int'(out_tokens), T - 1);
      chk("R10 data with owner", int'(out_data), 1);
      check_line(1);
      // R9: a lone non-owner token is kept
      cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      chk("R9 nothing sent", int'(out_valid), 0);
      // R12: same-line exclusive request and inbound message
      cyc(1, 1, 2, 0, 0, 1, 1, 1, 0, 0, 0);
      chk("R12 sent old count", int'(out_tokens), 1);
      check_line(1);
      chk("R12 new count", int'(q_count), 2);
      // R4: valid cleared at zero
      cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
      check_line(1);
      chk("R4 cleared", int'(q_valid), 0);
      // R11: parked read, retried on token change
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
      chk("R11 parked", int'(op_busy), 1);
      cyc(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      idle();
      chk("R11 still parked", int'(op_busy), 1);
      // R4: data without tokens has no effect
      cyc(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      check_line(1);
      cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
      idle();
      chk("R11 granted read", int'(op_busy), 0);
      // R3: overflow rejected
      cyc(1, 1, T, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R3 overflow flagged", int'(tok_err), 1);
      check_line(1);
      // R3: second owner rejected
      cyc(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
      chk("R3 dup owner flagged", int'(tok_err), 1);
      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         bit iv, io, id, xv, xx, ov, ow;
         int il, it, xl, ol;
         iv = ($urandom % 10) < 4;
         il = $urandom % 4;
         it = $urandom % (T + 1);
         io = ($urandom % 4) == 0;
         id = ($urandom % 2) == 0;
         xv = ($urandom % 10) < 3;
         xl = $urandom % 4;
         xx = ($urandom % 2) == 0;
         ov = !m_pend && (($urandom % 10) < 3);
         ow = ($urandom % 2) == 0;
         ol = $urandom % 4;
         cyc(iv, il, it, io, id, xv, xl, xx, ov, ow, ol);
         if ((n % 4) == 0) check_line($urandom % NL);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule